// File: doc/BRIEF.md
# Multi-Precision Packed Floating-Point Multiplier

This block is a pipelined binary floating-point multiplier that works on 128-bit packed operands. A two-bit mode input chooses how the operands are split. They can hold four binary32 lanes, two binary64 lanes, or a single binary128 value. Every lane forms its own product with round-to-nearest-even, so one issue yields four, two or one independent results.

Operations enter through a valid/ready handshake, and one may be accepted every cycle. Each result leaves as a single-cycle `out_valid` pulse, together with the packed product and four exception flags per lane. The binary128 path is one stage longer than the packed paths. For this reason the issue port holds off for exactly one cycle after a binary128 issue. This keeps results in issue order and stops two results from arriving on the output in the same cycle.

Top module: `mpfp_mul`

## Requirements
- R1: With `in_mode` = 2'b00, each operand carries four binary32 values, lane i at bits [32i+31:32i]. Result lane i is the product of operand lanes i, rounded to nearest-even, and is packed in the same way.
- R2: With `in_mode` = 2'b01, each operand carries two binary64 values, lane i at bits [64i+63:64i]. Each result lane is the rounded product of the matching operand lanes.
- R3: With `in_mode[1]` = 1 (2'b10 or 2'b11), all 128 operand bits form one binary128 value, and the result is its rounded binary128 product.
- R4: A binary32 or binary64 operation accepted in cycle c gives `out_valid` in cycle c+2. A binary128 operation gives `out_valid` in cycle c+3. Each accepted operation gives exactly one result pulse, and results leave in issue order.
- R5: `in_ready` is high out of reset. It is low for exactly the one cycle after a binary128 issue, and high in every other cycle.
- R6: Each lane's result sign is the XOR of its operand signs. An operand whose exponent field is zero (zero or subnormal) gives a zero of that sign with no flags raised.
- R7: A NaN operand gives the canonical quiet NaN, with no flag: sign 0, exponent all ones, only the top mantissa bit set. Infinity times zero gives the same NaN and raises invalid.
- R8: Infinity times a finite nonzero value gives an infinity of the XOR sign, with no flags raised.
- R9: If the rounded exponent reaches the all-ones value, the lane returns a signed infinity and raises overflow and inexact.
- R10: If the rounded exponent falls below the smallest normal exponent, the lane returns a signed zero and raises underflow and inexact.
- R11: Inexact is raised when rounding discards any nonzero bit. An exact halfway case rounds to the even significand.
- R12: The flags for lane i sit at `out_flags[4i+3:4i]` as {inexact, underflow, overflow, invalid}, with invalid at bit 4i. Flags of lanes that the current mode does not use are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_mode | input | 2 | 00 four binary32, 01 two binary64, 1x one binary128 |
| in_a | input | 128 | Packed first operand |
| in_b | input | 128 | Packed second operand |
| out_valid | output | 1 | Result present for one cycle |
| out_data | output | 128 | Packed result |
| out_flags | output | 16 | Four flags per lane |

## Verification
The assertions are checked on every cycle and cover the following timing and flag properties:
- the exact result latency of each mode;
- the one-cycle issue hold after a binary128 issue;
- overflow and underflow never appearing without inexact;
- flags staying zero in lanes that the result's mode leaves unused.

Some behaviour can only be shown by the bench's scenarios, which compare against values worked out independently. This covers the rounded values themselves: halfway ties, carries into the exponent, and signs. It also covers the special-value encodings in each lane of each format, and the order in which results leave under back-to-back mixed-mode traffic.

// File: rtl/mpfp_mul.sv
module mpfp_mul (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_mode,
  input  logic [127:0] in_a,
  input  logic [127:0] in_b,
  output logic         out_valid,
  output logic [127:0] out_data,
  output logic [15:0]  out_flags
);
  localparam int SP_EW = 8,  SP_MW = 23;
  localparam int DP_EW = 11, DP_MW = 52;
  localparam int QP_EW = 15, QP_MW = 112;

  // Returns {flags[3:0], result[127:0]}. The result is zero above the format width.
  // Flags: bit0 invalid, bit1 overflow, bit2 underflow, bit3 inexact.
  function automatic logic [131:0] fmul(input logic [127:0] a, input logic [127:0] b,
                                        input int ew, input int mw);
    logic [127:0] mm, res;
    logic [227:0] p, xa, xb;
    int ea, eb, e, emax, bias;
    logic s, an, bn, ai, bi, az, bz, hi, g, st, inc;
    logic [3:0] fl;
    mm   = (128'd1 << mw) - 128'd1;
    emax = (1 << ew) - 1;
    bias = emax >> 1;
    ea = int'((a >> mw) & 128'(emax));
    eb = int'((b >> mw) & 128'(emax));
    s  = a[mw+ew] ^ b[mw+ew];
    az = (ea == 0);
    bz = (eb == 0);
    ai = (ea == emax) && ((a & mm) == 128'd0);
    bi = (eb == emax) && ((b & mm) == 128'd0);
    an = (ea == emax) && ((a & mm) != 128'd0);
    bn = (eb == emax) && ((b & mm) != 128'd0);
    fl  = 4'd0;
    res = 128'(s) << (mw + ew);
    if (an || bn || (ai && bz) || (az && bi)) begin
      res   = (128'(emax) << mw) | (128'd1 << (mw - 1));
      fl[0] = (ai && bz) || (az && bi);
    end else if (ai || bi) begin
      res = res | (128'(emax) << mw);
    end else if (!(az || bz)) begin
      xa = 228'((a & mm) | (128'd1 << mw));
      xb = 228'((b & mm) | (128'd1 << mw));
      p  = xa * xb;
      hi = p[2*mw+1];
      if (!hi) p = p << 1;
      e   = ea + eb - bias + (hi ? 1 : 0);
      g   = p[mw];
      st  = |(p & ((228'd1 << mw) - 228'd1));
      p   = (p >> (mw + 1)) & ((228'd1 << (mw + 1)) - 228'd1);
      inc = g & (st | p[0]);
      p   = p + 228'(inc);
      if (p[mw+1]) begin
        p = p >> 1;
        e = e + 1;
      end
      fl[3] = g | st;
      if (e >= emax) begin
        res   = res | (128'(emax) << mw);
        fl[1] = 1'b1;
        fl[3] = 1'b1;
      end else if (e <= 0) begin
        fl[2] = 1'b1;
        fl[3] = 1'b1;
      end else begin
        res = res | (128'(e) << mw) | (p[127:0] & mm);
      end
    end
    return {fl, res};
  endfunction

  logic         s1_v, s1_q, s1_d;
  logic [127:0] s1_a, s1_b;
  logic         q_v;
  logic [127:0] q_d;
  logic [3:0]   q_f;
  logic [1:0]   o_mode;
  logic [131:0] sp [4];
  logic [131:0] dp [2];
  logic [131:0] qp;
  logic [127:0] sd_d;
  logic [15:0]  sd_f;

  assign in_ready = !(s1_v && s1_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_q <= 1'b0;
      s1_d <= 1'b0;
      s1_a <= '0;
      s1_b <= '0;
    end else begin
      s1_v <= in_valid && in_ready;
      s1_q <= in_mode[1];
      s1_d <= (in_mode == 2'b01);
      s1_a <= in_a;
      s1_b <= in_b;
    end

  for (genvar i = 0; i < 4; i++) begin : g_sp
    assign sp[i] = fmul({96'd0, s1_a[32*i +: 32]}, {96'd0, s1_b[32*i +: 32]}, SP_EW, SP_MW);
  end
  for (genvar i = 0; i < 2; i++) begin : g_dp
    assign dp[i] = fmul({64'd0, s1_a[64*i +: 64]}, {64'd0, s1_b[64*i +: 64]}, DP_EW, DP_MW);
  end
  assign qp = fmul(s1_a, s1_b, QP_EW, QP_MW);

  always_comb begin
    sd_d = '0;
    sd_f = '0;
    if (s1_d) begin
      for (int i = 0; i < 2; i++) begin
        sd_d = sd_d | (dp[i][127:0] << (64 * i));
        sd_f = sd_f | (16'(dp[i][131:128]) << (4 * i));
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        sd_d = sd_d | (sp[i][127:0] << (32 * i));
        sd_f = sd_f | (16'(sp[i][131:128]) << (4 * i));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_v <= 1'b0;
      q_d <= '0;
      q_f <= '0;
    end else begin
      q_v <= s1_v && s1_q;
      q_d <= qp[127:0];
      q_f <= qp[131:128];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
      o_mode    <= 2'b00;
    end else if (q_v) begin
      out_valid <= 1'b1;
      out_data  <= q_d;
      out_flags <= {12'd0, q_f};
      o_mode    <= 2'b10;
    end else if (s1_v && !s1_q) begin
      out_valid <= 1'b1;
      out_data  <= sd_d;
      out_flags <= sd_f;
      o_mode    <= {1'b0, s1_d};
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end

  a_r5_hold_after_quad: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode[1]) |=> !in_ready);
  a_r4_packed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_mode[1]) |=> ##1 out_valid);
  a_r4_quad_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode[1]) |=> ##2 out_valid);
  a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_flags >> 1) & ~(out_flags >> 3) & 16'h1111) == 16'd0));
  a_r10_unf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_flags >> 2) & ~(out_flags >> 3) & 16'h1111) == 16'd0));
  a_r12_quad_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_mode[1]) |-> (out_flags[15:4] == 12'd0));
  a_r12_double_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_mode == 2'b01) |-> (out_flags[15:8] == 8'd0));
endmodule

// File: tb/mpfp_mul_bench.sv
module mpfp_mul_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_mode = 2'b00;
  logic [127:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic [15:0]  out_flags;

  int nchk = 0, nfail = 0, cyc = 0;
  int           q_cyc [$];
  logic [127:0] q_dat [$];
  logic [15:0]  q_flg [$];
  string        q_tag [$];

  mpfp_mul u_mpfp_mul (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string what, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %h exp %h", what, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] ed, input logic [15:0] ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_a = a; in_b = b;
    while (!in_ready) @(negedge clk);
    q_cyc.push_back(cyc + (m[1] ? 3 : 2));
    q_dat.push_back(ed);
    q_flg.push_back(ef);
    q_tag.push_back(tag);
    @(posedge clk); #1;
    check(in_ready == !m[1], {tag, " R5 ready after issue"}, 128'(in_ready), 128'(!m[1]));
  endtask

  always @(negedge clk)
    if (rst_n && out_valid) begin
      if (q_dat.size() == 0) check(1'b0, "R4 result without issue", out_data, '0);
      else begin
        int c; logic [127:0] d; logic [15:0] f; string t;
        c = q_cyc.pop_front(); d = q_dat.pop_front(); f = q_flg.pop_front(); t = q_tag.pop_front();
        check(cyc == c, {t, " R4 result cycle"}, 128'(cyc), 128'(c));
        check(out_data == d, {t, " data"}, out_data, d);
        check(out_flags == f, {t, " flags"}, 128'(out_flags), 128'(f));
      end
    end

  function automatic logic [63:0] rb(input real x);
    return $realtobits(x);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    real x0, y0, x1, y1;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R5 reset state", {126'd0, out_valid, in_ready}, 128'd1);
    rst_n = 1'b1;

    // R1 R11: plain products and a halfway tie that rounds to even
    issue(2'b00, {32'h3f800003, 32'h40400000, 32'hc0200000, 32'h3fc00000},
                 {32'h3fc00000, 32'h40800000, 32'h3f000000, 32'h40000000},
                 {32'h3fc00004, 32'h41400000, 32'hbfa00000, 32'h40400000}, 16'h8000, "R1 R11 single");
    // R9 R10 R11: overflow, underflow with both signs, tie rounding up to even
    issue(2'b00, {32'h80800000, 32'h00800000, 32'h7f000000, 32'h3f800001},
                 {32'h3f000000, 32'h3f000000, 32'h40000000, 32'h3fc00000},
                 {32'h80000000, 32'h00000000, 32'h7f800000, 32'h3fc00002}, 16'hCCA8, "R9 R10 R11 single");
    // R6 R7 R8: subnormal flush, inf*finite, inf*zero, NaN operand
    issue(2'b00, {32'h00000001, 32'h7f800000, 32'h7f800000, 32'h7fc00001},
                 {32'hc0000000, 32'hc0000000, 32'h00000000, 32'h3f800000},
                 {32'h80000000, 32'hff800000, 32'h7fc00000, 32'h7fc00000}, 16'h0010, "R6 R7 R8 single");
    // R2 R12: two binary64 lanes, inexact only in lane 1
    x0 = 1.5; y0 = 2.5; x1 = 0.1; y1 = 0.3;
    issue(2'b01, {rb(x1), rb(x0)}, {rb(y1), rb(y0)}, {rb(x1 * y1), rb(x0 * y0)}, 16'h0080, "R2 R12 double");
    x0 = 1.0e300; y0 = 1.0e300; x1 = -3.0; y1 = 0.25;
    issue(2'b01, {rb(x1), rb(x0)}, {rb(y1), rb(y0)}, {rb(x1 * y1), rb(x0 * y0)}, 16'h000A, "R2 R6 R9 double");
    x0 = 1.0e-300; y0 = 1.0e-300;
    issue(2'b01, {64'h7ff8000000000001, rb(x0)}, {64'h3ff0000000000000, rb(y0)},
                 {64'h7ff8000000000000, 64'd0}, 16'h000C, "R2 R7 R10 double");
    // R3 R4 R5: binary128, then back-to-back binary128 issues, which must stall
    issue(2'b10, 128'h3fff8000_00000000_00000000_00000000, 128'h40000000_00000000_00000000_00000000,
                 128'h40008000_00000000_00000000_00000000, 16'h0000, "R3 quad");
    issue(2'b11, 128'h3fff0000_00000000_00000000_00000001, 128'h3fff0000_00000000_00000000_00000001,
                 128'h3fff0000_00000000_00000000_00000002, 16'h0008, "R3 R11 quad mode 11");
    issue(2'b10, 128'h3fff0000_00000000_00000000_00000003, 128'h3fff8000_00000000_00000000_00000000,
                 128'h3fff8000_00000000_00000000_00000004, 16'h0008, "R3 R11 quad tie");
    // R4: a packed issue right after a quad must wait, and its result follows the quad
    issue(2'b00, {4{32'h3fc00000}}, {4{32'h3fc00000}}, {4{32'h40100000}}, 16'h0000, "R4 single after quad");
    issue(2'b10, 128'hc0000000_00000000_00000000_00000000, 128'h3fff8000_00000000_00000000_00000000,
                 128'hc0008000_00000000_00000000_00000000, 16'h0000, "R3 R6 quad sign");
    issue(2'b10, 128'h7fff0000_00000000_00000000_00000000, 128'd0,
                 128'h7fff8000_00000000_00000000_00000000, 16'h0001, "R7 R12 quad invalid");
    x0 = 2.0; y0 = 0.75; x1 = -1.0; y1 = -1.0;
    issue(2'b01, {rb(x1), rb(x0)}, {rb(y1), rb(y0)}, {rb(x1 * y1), rb(x0 * y0)}, 16'h0000, "R4 R6 double after quad");
    @(negedge clk);
    in_valid = 1'b0;
    while (q_dat.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q_dat.size() == 0 && !out_valid, "R4 no extra result", 128'(out_valid), 128'd0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule